// File: doc/BRIEF.md
# Serial Real-Time Clock Device with Battery-Backed Word Store

This block is the device side of a real-time clock that hangs off a four-wire serial bus. The bus has a serial clock, an active-low select, a data input and a data output. The host opens a session by pulling select low and shifting in a 32-bit command word, most significant bit first. The top bit of that word says whether the access is a write. The bits below it carry a 24-bit register address, placed eight bits up from the bottom of the word. A second 32-bit phase follows in the same session. On a write the host shifts the data in; on a read the device shifts the data out.

Behind the serial port sit the following:
- a 32-bit seconds counter, advanced by a one-second tick input;
- sixteen words of general storage, one of which by convention holds the bias that host software adds to the counter to form wall-clock time;
- a snapshot word and two timer words;
- a group of read-only test words;
- a read-only control word and a writable control word.

Read access and write access are decoded separately. A read from an address outside the readable set returns zero. A write to an address outside the writable set changes nothing. The serial pins are oversampled in the system clock domain, so the serial clock must run several times slower than `clk_i`.

Top module: `serial_rtc`

## Requirements
- R1: A session starts when cs_ni falls. Bits are taken on rising edges of sck_i, most significant first. The command word is 32 bits: bit 31 = 1 marks a write, bits 30:8 give address bits 22:0, address bit 23 is zero, and bits 7:0 are ignored. A read command does not alter any register, whatever is shifted in during its data phase.
- R2: On a write, the 32 bits after the command word are stored to the addressed register once the 32nd data bit has been taken. Later bits in the same session have no effect.
- R3: On a read, the addressed register's value is captured at the first falling sck_i edge after the command word and presented on miso_o most significant bit first. Each later falling edge moves to the next bit.
- R4: The seconds counter at address 0x200000 increases by one for each tick_i pulse and wraps from 0xFFFFFFFF to 0.
- R5: A write to 0x200000 loads the counter with the written value, and that load takes priority over a tick in the same cycle.
- R6: Sixteen independent read/write storage words occupy 0x200001 to 0x200010. The bias word at 0x200004 is one of them.
- R7: The snapshot word (0x204000), on-timer (0x210000), off-timer (0x210001) and writable control word (0x21000D) are read/write. Each keeps its value unless it is written.
- R8: The test words at 0x210004 to 0x210007 read TEST_WORD OR'd with the low two address bits. The read-only control word at 0x21000C reads CTRL0_VALUE. Writes to any of these five addresses are ignored.
- R9: A read from any other address returns zero. A write to any other address changes no register.
- R10: Raising cs_ni abandons the session at any point. Nothing is written, miso_o returns to 0, and the next session starts with a fresh command word.
- R11: After reset, every register and storage word is zero and miso_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low session select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |

## Verification
The bench builds the block with its default command, data and address widths and with sixteen storage words. It sets TEST_WORD to 0x7E570000 and CTRL0_VALUE to 0xC0. With those nonzero constants, the read-only addresses can be told apart from unmapped ones, and a write that wrongly landed on them would show. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchronizer delay before each sample. With the full 32-bit counter, the wrap can be reached by loading 0xFFFFFFFF and sending one tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_COUNT    = 24'h200000;
  localparam addr_t A_SRAM     = 24'h200001;
  localparam int    SRAM_WORDS = 16;
  localparam addr_t A_SNAP     = 24'h204000;
  localparam addr_t A_ON_TMR   = 24'h210000;
  localparam addr_t A_OFF_TMR  = 24'h210001;
  localparam addr_t A_TEST     = 24'h210004;
  localparam int    TEST_WORDS = 4;
  localparam addr_t A_CTRL_RO  = 24'h21000C;
  localparam addr_t A_CTRL_RW  = 24'h21000D;

  typedef enum logic [3:0] {
    K_NONE, K_COUNT, K_SRAM, K_SNAP, K_ON, K_OFF, K_TEST, K_CTRL_RO, K_CTRL_RW
  } kind_e;

  function automatic kind_e decode(addr_t a);
    if (a == A_COUNT) return K_COUNT;
    if (32'(a) >= 32'(A_SRAM) && 32'(a) < 32'(A_SRAM) + SRAM_WORDS) return K_SRAM;
    if (a == A_SNAP) return K_SNAP;
    if (a == A_ON_TMR) return K_ON;
    if (a == A_OFF_TMR) return K_OFF;
    if (32'(a) >= 32'(A_TEST) && 32'(a) < 32'(A_TEST) + TEST_WORDS) return K_TEST;
    if (a == A_CTRL_RO) return K_CTRL_RO;
    if (a == A_CTRL_RW) return K_CTRL_RW;
    return K_NONE;
  endfunction

  function automatic logic writable(kind_e k);
    return !(k inside {K_NONE, K_TEST, K_CTRL_RO});
  endfunction
endpackage

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave #(
  parameter int CMD_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int MAX_W   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W   = $clog2(MAX_W);
  localparam int ADDR_LO = CMD_W - ADDR_W;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_e;

  logic [SYNC_N:0]   sck_s;
  logic [SYNC_N-1:0] cs_s, mosi_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[SYNC_N-1:0], sck_i};
      cs_s   <= {cs_s[SYNC_N-2:0], cs_ni};
      mosi_s <= {mosi_s[SYNC_N-2:0], mosi_i};
    end
  end

  logic sck_rise, sck_fall, bit_in;
  assign sck_rise = sck_s[SYNC_N-1] & ~sck_s[SYNC_N];
  assign sck_fall = ~sck_s[SYNC_N-1] & sck_s[SYNC_N];
  assign bit_in   = mosi_s[SYNC_N-1];
  assign active_o = ~cs_s[SYNC_N-1];

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-2:0] rx_q;
  logic [DATA_W-1:0] tx_q;
  logic              is_wr_q, load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      is_wr_q  <= 1'b0;
      load_q   <= 1'b0;
      addr_o   <= '0;
      wr_stb_o <= 1'b0;
      wdata_o  <= '0;
    end else if (!active_o) begin
      phase_q  <= PH_CMD;
      cnt_q    <= '0;
      tx_q     <= '0;
      load_q   <= 1'b0;
      wr_stb_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (sck_rise) begin
        rx_q  <= {rx_q[DATA_W-3:0], bit_in};
        cnt_q <= cnt_q + 1'b1;
        case (phase_q)
          PH_CMD: if (cnt_q == CNT_W'(CMD_W-1)) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            is_wr_q <= rx_q[CMD_W-2];
            addr_o  <= {1'b0, rx_q[CMD_W-3:ADDR_LO-1]};
            load_q  <= ~rx_q[CMD_W-2];
          end
          PH_DATA: if (cnt_q == CNT_W'(DATA_W-1)) begin
            phase_q <= PH_DONE;
            if (is_wr_q) begin
              wdata_o  <= {rx_q, bit_in};
              wr_stb_o <= 1'b1;
            end
          end
          default: cnt_q <= cnt_q;
        endcase
      end
      if (sck_fall) begin
        if (load_q) begin
          tx_q   <= rd_data_i;
          load_q <= 1'b0;
        end else begin
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o = tx_q[DATA_W-1];
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (tick_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int          NWORDS      = SRAM_WORDS,
  parameter logic [31:0] TEST_WORD   = 32'h0,
  parameter logic [31:0] CTRL0_VALUE = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  addr_t             addr_i,
  input  logic              wr_stb_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORD_W-1:0] count_o,
  output logic [WORD_W-1:0] ctrl_rw_o
);
  localparam int IDX_W = $clog2(NWORDS);

  kind_e             kind;
  logic              wr_ok;
  logic [IDX_W-1:0]  sidx;
  logic [ADDR_W-1:0] soff;

  assign kind  = decode(addr_i);
  assign wr_ok = wr_stb_i & writable(kind);
  assign soff  = addr_i - A_SRAM;
  assign sidx  = soff[IDX_W-1:0];

  rtc_sec_counter #(.WIDTH(WORD_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (wr_ok && kind == K_COUNT),
    .load_val_i (wdata_i),
    .count_o    (count_o)
  );

  logic [WORD_W-1:0] sram_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_sram
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sram_q[g] <= '0;
      else if (wr_ok && kind == K_SRAM && sidx == IDX_W'(g)) sram_q[g] <= wdata_i;
    end
  end

  logic [WORD_W-1:0] snap_q, on_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      on_q      <= '0;
      off_q     <= '0;
      ctrl_rw_o <= '0;
    end else if (wr_ok) begin
      case (kind)
        K_SNAP:    snap_q    <= wdata_i;
        K_ON:      on_q      <= wdata_i;
        K_OFF:     off_q     <= wdata_i;
        K_CTRL_RW: ctrl_rw_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_COUNT:   rd_data_o = count_o;
      K_SRAM:    rd_data_o = sram_q[sidx];
      K_SNAP:    rd_data_o = snap_q;
      K_ON:      rd_data_o = on_q;
      K_OFF:     rd_data_o = off_q;
      K_TEST:    rd_data_o = TEST_WORD | WORD_W'(addr_i[1:0]);
      K_CTRL_RO: rd_data_o = CTRL0_VALUE;
      K_CTRL_RW: rd_data_o = ctrl_rw_o;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/serial_rtc.sv
module serial_rtc
  import rtc_pkg::*;
#(
  parameter logic [31:0] TEST_WORD   = 32'h0,
  parameter logic [31:0] CTRL0_VALUE = 32'h0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  logic              sess_active;
  addr_t             acc_addr;
  logic              wr_stb;
  logic [WORD_W-1:0] wr_data, rd_data, sec_count, ctrl_rw;

  rtc_serial_slave #(
    .CMD_W  (32),
    .DATA_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (sck_i),
    .cs_ni     (cs_ni),
    .mosi_i    (mosi_i),
    .miso_o    (miso_o),
    .active_o  (sess_active),
    .addr_o    (acc_addr),
    .wr_stb_o  (wr_stb),
    .wdata_o   (wr_data),
    .rd_data_i (rd_data)
  );

  rtc_regs #(
    .NWORDS      (SRAM_WORDS),
    .TEST_WORD   (TEST_WORD),
    .CTRL0_VALUE (CTRL0_VALUE)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .addr_i    (acc_addr),
    .wr_stb_i  (wr_stb),
    .wdata_i   (wr_data),
    .rd_data_o (rd_data),
    .count_o   (sec_count),
    .ctrl_rw_o (ctrl_rw)
  );
endmodule

// File: rtl/serial_rtc_checker.sv
module serial_rtc_checker
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              active_i,
  input addr_t             addr_i,
  input logic              wr_stb_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [WORD_W-1:0] count_i,
  input logic [WORD_W-1:0] ctrl_rw_i,
  input logic              miso_o
);
  logic cnt_wr;
  assign cnt_wr = wr_stb_i && addr_i == A_COUNT;

  AST_CNT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr |=> count_i == $past(count_i) + 1'b1); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_wr |=> $stable(count_i)); // R4
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> count_i == $past(wdata_i)); // R5
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && addr_i == A_CTRL_RW) |=> $stable(ctrl_rw_i)); // R7
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !wr_stb_i); // R2
  AST_IDLE_MISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !miso_o && !wr_stb_i); // R10
endmodule

bind serial_rtc serial_rtc_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .active_i  (sess_active),
  .addr_i    (acc_addr),
  .wr_stb_i  (wr_stb),
  .wdata_i   (wr_data),
  .count_i   (sec_count),
  .ctrl_rw_i (ctrl_rw),
  .miso_o    (miso_o)
);

// File: tb/serial_rtc_tb.sv
module serial_rtc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [31:0] TW = 32'h7E57_0000;
  localparam logic [31:0] C0 = 32'h0000_00C0;

  logic clk = 0, rst_ni = 0, tick = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rtc #(.TEST_WORD(TW), .CTRL0_VALUE(C0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso)
  );

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'h200001, 32'h1111_1111, 32'h0},
    '{1'b1, 24'h200004, 32'h1234_5678, 32'h0},
    '{1'b1, 24'h200010, 32'hDEAD_BEEF, 32'h0},
    '{1'b1, 24'h204000, 32'hCAFE_0001, 32'h0},
    '{1'b1, 24'h210000, 32'h0000_003C, 32'h0},
    '{1'b1, 24'h210001, 32'h0000_0077, 32'h0},
    '{1'b1, 24'h21000D, 32'h0000_00A5, 32'h0},
    '{1'b1, 24'h210005, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 24'h21000C, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 24'h200011, 32'h0000_0001, 32'h0},
    '{1'b1, 24'h204001, 32'h0000_0002, 32'h0},
    '{1'b0, 24'h200001, 32'hFFFF_FFFF, 32'h1111_1111},
    '{1'b0, 24'h200004, 32'hFFFF_FFFF, 32'h1234_5678},
    '{1'b0, 24'h200010, 32'hFFFF_FFFF, 32'hDEAD_BEEF},
    '{1'b0, 24'h200003, 32'h0,         32'h0},
    '{1'b0, 24'h204000, 32'hFFFF_FFFF, 32'hCAFE_0001},
    '{1'b0, 24'h204000, 32'h0,         32'hCAFE_0001},
    '{1'b0, 24'h210000, 32'h0,         32'h0000_003C},
    '{1'b0, 24'h210001, 32'h0,         32'h0000_0077},
    '{1'b0, 24'h21000D, 32'h0,         32'h0000_00A5},
    '{1'b0, 24'h210005, 32'h0,         32'h7E57_0001},
    '{1'b0, 24'h210007, 32'h0,         32'h7E57_0003},
    '{1'b0, 24'h21000C, 32'h0,         32'h0000_00C0},
    '{1'b0, 24'h200011, 32'h0,         32'h0},
    '{1'b0, 24'h204001, 32'h0,         32'h0},
    '{1'b0, 24'h210002, 32'h0,         32'h0}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    mosi = b;
    wait_clk(HALF);
    s = miso;
    sck = 1;
    wait_clk(HALF);
    sck = 0;
  endtask

  task automatic xfer(input logic wr, input logic [23:0] addr,
                      input logic [31:0] wd, output logic [31:0] rd);
    logic [31:0] cmd;
    logic s;
    cmd = {8'h00, addr} << 8;
    cmd[31] = wr;
    cs_n = 0;
    wait_clk(HALF);
    for (int i = 31; i >= 0; i--) bit_xfer(cmd[i], s);
    for (int i = 31; i >= 0; i--) begin
      bit_xfer(wd[i], s);
      rd[i] = s;
    end
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(2 * HALF);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      wait_clk(1);
      tick = 0;
      wait_clk(2);
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic s;
    wait_clk(3);
    check("R11 miso reset", {31'b0, miso}, 32'h0);
    rst_ni = 1;
    wait_clk(3);

    xfer(1'b0, 24'h200000, 32'h0, rd);
    check("R11 counter reset", rd, 32'h0);
    xfer(1'b0, 24'h200004, 32'h0, rd);
    check("R11 bias reset", rd, 32'h0);

    // table walk: R1 R2 R3 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].wr, VEC[i].addr, VEC[i].wd, rd);
      if (!VEC[i].wr) check($sformatf("R3/R6-R9 vec %0d", i), rd, VEC[i].exp);
    end

    // R5 load then R4 ticks
    xfer(1'b1, 24'h200000, 32'h0000_0005, rd);
    pulse_tick(3);
    xfer(1'b0, 24'h200000, 32'h0, rd);
    check("R4 R5 count after load+3 ticks", rd, 32'h0000_0008);

    // R4 wrap
    xfer(1'b1, 24'h200000, 32'hFFFF_FFFF, rd);
    pulse_tick(1);
    xfer(1'b0, 24'h200000, 32'h0, rd);
    check("R4 wrap", rd, 32'h0);

    // R10 abort mid-session with write flag set
    cs_n = 0;
    wait_clk(HALF);
    for (int i = 0; i < 40; i++) bit_xfer(1'b1, s);
    cs_n = 1;
    wait_clk(4);
    check("R10 miso idle", {31'b0, miso}, 32'h0);
    wait_clk(2 * HALF);
    xfer(1'b0, 24'h210000, 32'h0, rd);
    check("R10 fresh session after abort", rd, 32'h0000_003C);
    xfer(1'b0, 24'h200004, 32'h0, rd);
    check("R10 bias intact", rd, 32'h1234_5678);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule